// File: doc/BRIEF.md
# Streaming GCR Group Decoder

This block translates group-coded recording data, as read from a floppy disk surface, back into plain binary while the data is still arriving. A host processor hands the raw code bytes to the block one at a time through a small register window on its memory bus. After every fifth code byte the block has a complete 40-bit group. It cuts the group into eight 5-bit codes, looks each one up in a fixed table to get a 4-bit nibble, and offers the resulting four data bytes for readback.

The first four code bytes of a group are captured in edge-triggered registers. A synchronous slot counter enables these loads, so no enable is taken from decoded counter outputs that could glitch. The fifth byte is translated straight from the bus during its write cycle. The decoded bytes and the ready flag therefore update on the same clock edge that accepts the last byte of the group, so a result is always in place before the next group begins. A code that is missing from the table raises a sticky error flag. A write to the status register clears the flags and restarts the group count, which lets software realign after a sync mark.

Top module: `gcr_group_decoder`

## Requirements
- R1: After reset, every readable offset (0 to 7) returns 0x00.
- R2: A bus write (cs=1, we=1) to offset 0 stores the write data as the next code byte and advances the slot count 0,1,2,3,4. The count is visible in status bits [2:0] from the clock edge that accepts the write.
- R3: The write that fills slot 4 completes the group. On that same edge the slot count returns to 0, ready (status bit 7) becomes 1, and offsets 0 to 3 present the decoded bytes.
- R4: The 40-bit group is formed from the code bytes in arrival order, first byte in bits 39:32. It is split into codes from the most significant end (code 0 = bits 39:35). Decoded byte k is the nibble of code 2k in bits 7:4 and the nibble of code 2k+1 in bits 3:0, and it is read at offset k.
- R5: Codes map to nibbles as 01010→0, 01011→1, 10010→2, 10011→3, 01110→4, 01111→5, 10110→6, 10111→7, 01001→8, 11001→9, 11010→A, 11011→B, 01101→C, 11101→D, 11110→E, 10101→F.
- R6: A code outside the table decodes as nibble 0 and sets error (status bit 6). The error stays set through later valid groups.
- R7: Any bus write to offset 4 clears ready, error and the slot count on the next edge. It leaves the decoded bytes unchanged.
- R8: A write to offsets 1, 2, 3, 5, 6 or 7, or any write with cs=0, leaves the slot count, the flags and the decoded bytes unchanged.
- R9: Offsets 0 to 3 hold the last completed group until the next group completes. Partial groups do not alter them.
- R10: The status byte is {ready, error, 3'b000, slot[2:0]}, and offsets 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select for the register window |
| bus_we | input | 1 | Write strobe (1 = write) |
| bus_addr | input | 3 | Register offset inside the window |
| bus_wdata | input | 8 | Write data (code byte or status clear) |
| bus_rdata | output | 8 | Read data for the selected offset |

## Verification
The decoder is driven with random 32-bit words, each encoded in the bench from the table and fed as five code bytes. It is also given two fixed words that between them use all sixteen nibbles, which separates a wrong table entry from a wrong nibble or byte position. Status is read after every single write, which exposes off-by-one slot sequencing and a wrap at the wrong point. Groups with an unmapped code placed mid-group, followed by valid groups, show whether the error flag is sticky and whether the bad position reads as zero. Stray writes, writes with chip select low and a status clear issued mid-group show whether each one is ignored or resynchronises as required.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
    localparam int CODE_W      = 5;
    localparam int NIB_W       = 4;
    localparam int BYTE_W      = 8;
    localparam int IN_BYTES    = 5;
    localparam int OUT_BYTES   = 4;
    localparam int GROUP_W     = IN_BYTES * BYTE_W;
    localparam int OUT_W       = OUT_BYTES * BYTE_W;
    localparam int N_CODES     = GROUP_W / CODE_W;
    localparam int SLOT_W      = $clog2(IN_BYTES);
    localparam int ADDR_W      = 3;
    localparam int STAGED_W    = (IN_BYTES - 1) * BYTE_W;

    localparam logic [ADDR_W-1:0] OFF_LOAD = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

    typedef struct packed {
        logic [OUT_W-1:0] dec;
        logic             ready;
        logic             err;
    } dec_state_t;
endpackage

// File: rtl/gcr_slot_seq.sv
module gcr_slot_seq
    import gcr_pkg::*;
#(
    parameter int N = IN_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              clr,
    output logic [SLOT_W-1:0] slot,
    output logic [N-2:0]      load_en,
    output logic              wrap
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N - 1);

    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr)
            slot_d = '0;
        else if (adv)
            slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    generate
        for (genvar k = 0; k < N - 1; k++) begin : g_en
            assign load_en[k] = adv && !clr && (slot_q == SLOT_W'(k));
        end
    endgenerate

    assign wrap = adv && !clr && (slot_q == LAST);
    assign slot = slot_q;
endmodule

// File: rtl/gcr_stage.sv
module gcr_stage
    import gcr_pkg::*;
#(
    parameter int DEPTH = IN_BYTES - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        load_en,
    input  logic [BYTE_W-1:0]       din,
    output logic [DEPTH*BYTE_W-1:0] staged
);
    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_byte
            logic [BYTE_W-1:0] b_d, b_q;

            always_comb begin
                b_d = b_q;
                if (load_en[k]) b_d = din;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= '0;
                else        b_q <= b_d;
            end

            assign staged[DEPTH*BYTE_W-1-k*BYTE_W -: BYTE_W] = b_q;
        end
    endgenerate
endmodule

// File: rtl/gcr_nibble_rom.sv
module gcr_nibble_rom
    import gcr_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [NIB_W-1:0]  nib,
    output logic              bad
);
    always_comb begin
        bad = 1'b0;
        case (code)
            5'b01010: nib = 4'h0;
            5'b01011: nib = 4'h1;
            5'b10010: nib = 4'h2;
            5'b10011: nib = 4'h3;
            5'b01110: nib = 4'h4;
            5'b01111: nib = 4'h5;
            5'b10110: nib = 4'h6;
            5'b10111: nib = 4'h7;
            5'b01001: nib = 4'h8;
            5'b11001: nib = 4'h9;
            5'b11010: nib = 4'hA;
            5'b11011: nib = 4'hB;
            5'b01101: nib = 4'hC;
            5'b11101: nib = 4'hD;
            5'b11110: nib = 4'hE;
            5'b10101: nib = 4'hF;
            default: begin
                nib = 4'h0;
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/gcr_group_decoder.sv
module gcr_group_decoder
    import gcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic                load_wr, stat_wr, wrap;
    logic [SLOT_W-1:0]   slot;
    logic [IN_BYTES-2:0] load_en;
    logic [STAGED_W-1:0] staged;
    logic [GROUP_W-1:0]  group;
    logic [OUT_W-1:0]    dec_word;
    logic [N_CODES-1:0]  bad_vec;
    dec_state_t          st_d, st_q;

    assign load_wr = bus_cs && bus_we && (bus_addr == OFF_LOAD);
    assign stat_wr = bus_cs && bus_we && (bus_addr == OFF_STAT);

    gcr_slot_seq #(.N(IN_BYTES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (load_wr),
        .clr     (stat_wr),
        .slot    (slot),
        .load_en (load_en),
        .wrap    (wrap)
    );

    gcr_stage #(.DEPTH(IN_BYTES - 1)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .din     (bus_wdata),
        .staged  (staged)
    );

    assign group = {staged, bus_wdata};

    generate
        for (genvar i = 0; i < N_CODES; i++) begin : g_rom
            gcr_nibble_rom u_rom (
                .code (group[GROUP_W-1-i*CODE_W -: CODE_W]),
                .nib  (dec_word[OUT_W-1-i*NIB_W -: NIB_W]),
                .bad  (bad_vec[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.ready = 1'b0;
            st_d.err   = 1'b0;
        end else if (wrap) begin
            st_d.dec   = dec_word;
            st_d.ready = 1'b1;
            st_d.err   = st_q.err | (|bad_vec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(OUT_BYTES))
            bus_rdata = st_q.dec[OUT_W-1-int'(bus_addr)*BYTE_W -: BYTE_W];
        else if (bus_addr == OFF_STAT)
            bus_rdata = {st_q.ready, st_q.err, {(BYTE_W-2-SLOT_W){1'b0}}, slot};
    end
endmodule

// File: rtl/gcr_decoder_checker.sv
module gcr_decoder_checker
    import gcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_wr,
    input logic              stat_wr,
    input logic [SLOT_W-1:0] slot,
    input logic              ready,
    input logic              err,
    input logic [OUT_W-1:0]  dec
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(IN_BYTES - 1);

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && !stat_wr && slot != LAST) |=> slot == $past(slot) + 1'b1);

    assert_group_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && slot == LAST) |=> (slot == '0 && ready));

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (slot == '0 && !ready && !err && $stable(dec)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !stat_wr) |=> err);

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_wr && slot == LAST) |=> $stable(dec));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && !stat_wr) |=> ($stable(slot) && $stable(ready) && $stable(err)));
endmodule

bind gcr_group_decoder gcr_decoder_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_wr (load_wr),
    .stat_wr (stat_wr),
    .slot    (slot),
    .ready   (st_q.ready),
    .err     (st_q.err),
    .dec     (st_q.dec)
);

// File: tb/tb_gcr_group_decoder.sv
module tb_gcr_group_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int         m_slot = 0;
    bit         m_ready = 0, m_err = 0;
    logic [7:0] m_out [4];
    logic [7:0] m_stage [5];

    always #2 clk = ~clk;

    gcr_group_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b01010; 4'h1: return 5'b01011;
            4'h2: return 5'b10010; 4'h3: return 5'b10011;
            4'h4: return 5'b01110; 4'h5: return 5'b01111;
            4'h6: return 5'b10110; 4'h7: return 5'b10111;
            4'h8: return 5'b01001; 4'h9: return 5'b11001;
            4'hA: return 5'b11010; 4'hB: return 5'b11011;
            4'hC: return 5'b01101; 4'hD: return 5'b11101;
            4'hE: return 5'b11110; default: return 5'b10101;
        endcase
    endfunction

    function automatic logic [39:0] encode_word(input logic [31:0] w);
        logic [39:0] g = '0;
        for (int i = 0; i < 8; i++) g[39-5*i -: 5] = enc(w[31-4*i -: 4]);
        return g;
    endfunction

    function automatic logic [7:0] expect_rd(input logic [2:0] a);
        if (a < 3'd4) return m_out[a];
        if (a == 3'd4) return {m_ready, m_err, 3'b000, 3'(m_slot)};
        return 8'h00;
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd0) begin
            m_stage[m_slot] = d;
            m_slot++;
            if (m_slot == 5) begin
                logic [39:0] g;
                g = {m_stage[0], m_stage[1], m_stage[2], m_stage[3], m_stage[4]};
                for (int i = 0; i < 8; i++) begin
                    logic [3:0] nib = 4'h0;
                    bit found = 0;
                    for (int n = 0; n < 16; n++)
                        if (enc(4'(n)) == g[39-5*i -: 5]) begin nib = 4'(n); found = 1; end
                    if (!found) m_err = 1;
                    m_out[i/2][7-4*(i%2) -: 4] = nib;
                end
                m_ready = 1;
                m_slot = 0;
            end
        end else if (a == 3'd4) begin
            m_ready = 0; m_err = 0; m_slot = 0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit sel = 1);
        @(negedge clk);
        bus_cs = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_cs = 1'b0; bus_we = 1'b0;
        if (sel) model_write(a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        e = expect_rd(a);
        total++;
        if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s offset %0d actual=%02h expected=%02h", req, a, bus_rdata, e);
        end
        bus_cs = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) rd_chk(3'(a), req);
    endtask

    task automatic feed_group(input logic [39:0] g, input string req);
        for (int k = 0; k < 5; k++) begin
            wr(3'd0, g[39-8*k -: 8]);
            rd_chk(3'd4, req);
        end
        check_all(req);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) m_out[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        check_all("R1");

        // R2 R3 R5: all sixteen table entries over two groups, status after each write
        feed_group(encode_word(32'h01234567), "R2_R3_R5");
        feed_group(encode_word(32'h89ABCDEF), "R2_R3_R5");

        // R4: random words, byte and nibble placement
        for (int r = 0; r < 20; r++) feed_group(encode_word($urandom), "R4");

        // R8 R9: stray writes mid-group
        wr(3'd0, 8'h5A);
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h12);
        wr(3'd5, 8'hFF); wr(3'd6, 8'h77); wr(3'd7, 8'h33);
        wr(3'd0, 8'hC3, 0);
        wr(3'd4, 8'h00, 0);
        check_all("R8_R9_R10");

        // R7: status write mid-group resynchronises, data kept
        wr(3'd4, 8'hFF);
        check_all("R7");
        feed_group(encode_word(32'hDEADBEEF), "R7");

        // R6: unmapped code in code position 3, then sticky across a valid group
        begin
            logic [39:0] g = encode_word(32'h13579BDF);
            g[39-5*3 -: 5] = 5'b00000;
            feed_group(g, "R6");
            g = encode_word(32'h2468ACE0);
            g[4:0] = 5'b11111;
            feed_group(g, "R6");
            feed_group(encode_word(32'hCAFEF00D), "R6");
        end
        wr(3'd4, 8'h00);
        check_all("R7");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule